// File: doc/BRIEF.md
# Paged Address Translator with Fault Reporting

This block turns a logical address into a physical address using a small page table kept in its own registers. A logical address is split into a page number and a byte offset inside the page. Pages and physical frames share one fixed size, so the offset passes through unchanged. Only the page number is translated, into a frame number taken from the table.

Each lookup is first checked against a programmable table length. A page number at or beyond that length is rejected as out of range. A page number inside the table whose entry is marked absent produces a page-fault indication and no address. Every other lookup yields the frame number placed above the offset.

Software fills the table through a write port that carries an entry index, a frame number and a present bit. It sets the length through a separate write strobe. The result is registered and appears one cycle after the request, with a strobe.

Top module: `pgx_translator`

## Requirements
- R1: After reset, no response strobe is raised, every table entry is absent and the table length is 0, so any lookup is reported out of range.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. When `rsp_valid` is low, `rsp_oor`, `rsp_fault` and `rsp_paddr` are all 0.
- R3: A lookup whose page number is below the table length and whose entry is present returns `rsp_paddr` = {frame[7:0], offset[8:0]}: the frame fills bits 16..9 and the offset fills bits 8..0. Both flags are 0.
- R4: A lookup whose page number is greater than or equal to the table length raises `rsp_oor`.
- R5: A lookup whose page number is within the length but whose entry's present bit is 0 raises `rsp_fault`.
- R6: The range check wins over the present check. A page outside the length is reported only as out of range, even when its entry is absent. `rsp_oor` and `rsp_fault` are never high together.
- R7: A table write in the same cycle as a lookup of the same entry does not affect that lookup. The lookup uses the old contents, and the new contents apply from the next cycle.
- R8: A length write in the same cycle as a lookup does not affect that lookup. Length values above 16 leave every page in range.
- R9: Whenever either flag is high, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_page | input | 4 | Page number of the logical address |
| req_offset | input | 9 | Byte offset within the page |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 4 | Entry to write |
| tbl_frame | input | 8 | Frame number to store |
| tbl_present | input | 1 | Present bit to store |
| len_we | input | 1 | Table length write strobe |
| len_value | input | 5 | New table length, in entries |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_paddr | output | 17 | Physical address, 0 when a flag is set |
| rsp_oor | output | 1 | Page number not below the table length |
| rsp_fault | output | 1 | Page within the length but entry absent |

## Verification
The checker watches several properties on every cycle: the one-cycle strobe timing, the exclusive flags, the zeroed address on a flag, the offset passing through, and the range decision, which it tracks against its own copy of the length. Which frame number comes back, the fault on an absent entry, and the old-versus-new contents on a write that collides with a lookup all depend on table history. Only the bench's scenarios show these, because the bench keeps its own model of the table and checks each response against it. Reset in mid-run, the priority case of an absent entry beyond the length, and lengths above the entry count are covered in the same way.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    typedef enum logic [1:0] {
        XK_MAPPED = 2'd0,
        XK_RANGE  = 2'd1,
        XK_ABSENT = 2'd2
    } xl_kind_e;
endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
    parameter int PAGE_ID_W = 4,
    parameter int FRAME_W   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAGE_ID_W-1:0] wr_idx,
    input  logic [FRAME_W-1:0]   wr_frame,
    input  logic                 wr_present,
    input  logic [PAGE_ID_W-1:0] rd_idx,
    output logic [FRAME_W-1:0]   rd_frame,
    output logic                 rd_present
);
    localparam int ENTRIES = 1 << PAGE_ID_W;

    typedef struct packed {
        logic               present;
        logic [FRAME_W-1:0] frame;
    } ent_t;

    ent_t [ENTRIES-1:0] tab_d, tab_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_comb begin
            tab_d[i] = tab_q[i];
            if (wr_en && (wr_idx == PAGE_ID_W'(i))) begin
                tab_d[i].present = wr_present;
                tab_d[i].frame   = wr_frame;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tab_q[i] <= '0;
            end else begin
                tab_q[i] <= tab_d[i];
            end
        end
    end

    assign rd_frame   = tab_q[rd_idx].frame;
    assign rd_present = tab_q[rd_idx].present;
endmodule

// File: rtl/pgx_resolve.sv
module pgx_resolve
    import pgx_pkg::*;
#(
    parameter int PAGE_ID_W = 4,
    parameter int OFFSET_W  = 9,
    parameter int FRAME_W   = 8
) (
    input  logic [PAGE_ID_W-1:0]        page,
    input  logic [OFFSET_W-1:0]         offset,
    input  logic [PAGE_ID_W:0]          tbl_len,
    input  logic [FRAME_W-1:0]          ent_frame,
    input  logic                        ent_present,
    output xl_kind_e                    kind,
    output logic [FRAME_W+OFFSET_W-1:0] paddr
);
    logic in_range;

    always_comb begin
        in_range = ({1'b0, page} < tbl_len);
        if (!in_range) begin
            kind = XK_RANGE;
        end else if (!ent_present) begin
            kind = XK_ABSENT;
        end else begin
            kind = XK_MAPPED;
        end
        paddr = {ent_frame, offset};
    end
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
    import pgx_pkg::*;
#(
    parameter int PAGE_ID_W = 4,
    parameter int OFFSET_W  = 9,
    parameter int FRAME_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [PAGE_ID_W-1:0]        req_page,
    input  logic [OFFSET_W-1:0]         req_offset,
    input  logic                        tbl_we,
    input  logic [PAGE_ID_W-1:0]        tbl_idx,
    input  logic [FRAME_W-1:0]          tbl_frame,
    input  logic                        tbl_present,
    input  logic                        len_we,
    input  logic [PAGE_ID_W:0]          len_value,
    output logic                        rsp_valid,
    output logic [FRAME_W+OFFSET_W-1:0] rsp_paddr,
    output logic                        rsp_oor,
    output logic                        rsp_fault
);
    localparam int PADDR_W = FRAME_W + OFFSET_W;
    localparam int LEN_W   = PAGE_ID_W + 1;

    typedef struct packed {
        logic               vld;
        logic               oor;
        logic               flt;
        logic [PADDR_W-1:0] pa;
        logic [LEN_W-1:0]   len;
    } st_t;

    st_t st_d, st_q;

    logic [FRAME_W-1:0] ent_frame;
    logic               ent_present;
    xl_kind_e           kind;
    logic [PADDR_W-1:0] cand_pa;

    pgx_table #(
        .PAGE_ID_W(PAGE_ID_W),
        .FRAME_W  (FRAME_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_we),
        .wr_idx    (tbl_idx),
        .wr_frame  (tbl_frame),
        .wr_present(tbl_present),
        .rd_idx    (req_page),
        .rd_frame  (ent_frame),
        .rd_present(ent_present)
    );

    pgx_resolve #(
        .PAGE_ID_W(PAGE_ID_W),
        .OFFSET_W (OFFSET_W),
        .FRAME_W  (FRAME_W)
    ) u_resolve (
        .page       (req_page),
        .offset     (req_offset),
        .tbl_len    (st_q.len),
        .ent_frame  (ent_frame),
        .ent_present(ent_present),
        .kind       (kind),
        .paddr      (cand_pa)
    );

    always_comb begin
        st_d     = st_q;
        st_d.len = len_we ? len_value : st_q.len;
        st_d.vld = req_valid;
        st_d.oor = req_valid && (kind == XK_RANGE);
        st_d.flt = req_valid && (kind == XK_ABSENT);
        st_d.pa  = (req_valid && (kind == XK_MAPPED)) ? cand_pa : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.vld;
    assign rsp_oor   = st_q.oor;
    assign rsp_fault = st_q.flt;
    assign rsp_paddr = st_q.pa;
endmodule

// File: rtl/pgx_translator_chk.sv
module pgx_translator_chk #(
    parameter int PAGE_ID_W = 4,
    parameter int OFFSET_W  = 9,
    parameter int FRAME_W   = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [PAGE_ID_W-1:0]        req_page,
    input logic [OFFSET_W-1:0]         req_offset,
    input logic                        len_we,
    input logic [PAGE_ID_W:0]          len_value,
    input logic                        rsp_valid,
    input logic [FRAME_W+OFFSET_W-1:0] rsp_paddr,
    input logic                        rsp_oor,
    input logic                        rsp_fault
);
    logic [PAGE_ID_W:0] shadow_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_len <= '0;
        end else if (len_we) begin
            shadow_len <= len_value;
        end
    end

    p_strobe_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_oor && !rsp_fault && rsp_paddr == '0));

    p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_oor && rsp_fault));

    p_zero_on_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_oor || rsp_fault) |-> rsp_paddr == '0);

    p_offset_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_oor || rsp_fault ||
                       rsp_paddr[OFFSET_W-1:0] == $past(req_offset)));

    p_range_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_page} >= shadow_len)) |=> rsp_oor);

    p_range_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_page} < shadow_len)) |=> !rsp_oor);
endmodule

bind pgx_translator pgx_translator_chk #(
    .PAGE_ID_W(PAGE_ID_W),
    .OFFSET_W (OFFSET_W),
    .FRAME_W  (FRAME_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_page  (req_page),
    .req_offset(req_offset),
    .len_we    (len_we),
    .len_value (len_value),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_oor   (rsp_oor),
    .rsp_fault (rsp_fault)
);

// File: tb/tb_pgx_translator.sv
module tb_pgx_translator;
    localparam int PW = 4;
    localparam int OW = 9;
    localparam int FW = 8;
    localparam int AW = FW + OW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [PW-1:0] req_page = '0;
    logic [OW-1:0] req_offset = '0;
    logic          tbl_we = 1'b0;
    logic [PW-1:0] tbl_idx = '0;
    logic [FW-1:0] tbl_frame = '0;
    logic          tbl_present = 1'b0;
    logic          len_we = 1'b0;
    logic [PW:0]   len_value = '0;
    logic          rsp_valid;
    logic [AW-1:0] rsp_paddr;
    logic          rsp_oor;
    logic          rsp_fault;

    always #4 clk = ~clk;

    pgx_translator dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_page(req_page),
        .req_offset(req_offset), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_frame(tbl_frame), .tbl_present(tbl_present), .len_we(len_we),
        .len_value(len_value), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_oor(rsp_oor), .rsp_fault(rsp_fault)
    );

    typedef struct {
        int            cyc;
        logic          oor;
        logic          flt;
        logic [AW-1:0] pa;
        string         tag;
    } exp_t;

    exp_t          sb[$];
    int            checks = 0;
    int            failures = 0;
    int            cyc = 0;
    logic [FW-1:0] m_frame [16];
    logic          m_pres  [16];
    logic [PW:0]   m_len;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_frame[i] = '0;
            m_pres[i]  = 1'b0;
        end
        m_len = '0;
    endtask

    // One cycle of stimulus, driven at a falling edge.
    task automatic step(input bit rq, input int pg, input int off,
                        input bit we, input int idx, input int fr, input bit pr,
                        input bit lw, input int ln, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = rq; req_page = PW'(pg); req_offset = OW'(off);
        tbl_we = we; tbl_idx = PW'(idx); tbl_frame = FW'(fr); tbl_present = pr;
        len_we = lw; len_value = (PW+1)'(ln);
        if (rq) begin
            e.cyc = cyc; e.tag = tag;
            e.oor = ({1'b0, PW'(pg)} >= m_len);
            e.flt = !e.oor && !m_pres[pg];
            e.pa  = (e.oor || e.flt) ? '0 : {m_frame[pg], OW'(off)};
            sb.push_back(e);
        end
        if (we) begin
            m_frame[idx] = FW'(fr);
            m_pres[idx]  = pr;
        end
        if (lw) m_len = (PW+1)'(ln);
    endtask

    task automatic lookup(input int pg, input int off, input string tag);
        step(1, pg, off, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input int idx, input int fr, input bit pr);
        step(0, 0, 0, 1, idx, fr, pr, 0, 0, "");
    endtask

    task automatic setlen(input int ln);
        step(0, 0, 0, 0, 0, 0, 0, 1, ln, "");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    endtask

    // Monitor: compares each response with the scoreboard at falling edges.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (sb.size() > 0 && sb[0].cyc < cyc) begin
                    exp_t e;
                    e = sb.pop_front();
                    checks++;
                    if (rsp_valid !== 1'b1 || rsp_oor !== e.oor ||
                        rsp_fault !== e.flt || rsp_paddr !== e.pa) begin
                        failures++;
                        $display("FAIL %s: got v=%0b oor=%0b flt=%0b pa=%h, exp v=1 oor=%0b flt=%0b pa=%h",
                                 e.tag, rsp_valid, rsp_oor, rsp_fault, rsp_paddr,
                                 e.oor, e.flt, e.pa);
                    end
                end else begin
                    checks++;
                    if (rsp_valid !== 1'b0 || rsp_oor !== 1'b0 ||
                        rsp_fault !== 1'b0 || rsp_paddr !== '0) begin
                        failures++;
                        $display("FAIL R2 idle: got v=%0b oor=%0b flt=%0b pa=%h, exp all 0",
                                 rsp_valid, rsp_oor, rsp_fault, rsp_paddr);
                    end
                end
            end
        end
    end

    task automatic run_all();
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);                          // R1: quiet after reset
        lookup(0, 5, "R1 len0 rejects");   // R1/R4
        setlen(16);
        lookup(3, 7, "R1 entries absent"); // R1/R5
        wr(3, 'hA5, 1); wr(7, 'h3C, 1); wr(15, 'hFF, 1);
        wr(0, 'h00, 1); wr(9, 'h12, 0);
        lookup(3, 'h1FF, "R3 top offset");
        lookup(7, 0, "R3 zero offset");
        lookup(15, 'h155, "R3 last page");
        lookup(0, 0, "R3 all-zero address");
        lookup(9, 'h20, "R5 absent entry");
        idle(1);
        setlen(8);
        lookup(7, 'h0AA, "R4 last page in range");
        lookup(8, 1, "R4 page equals length");
        lookup(15, 2, "R6 present but beyond length");
        lookup(9, 3, "R6 absent and beyond length");
        step(1, 7, 'h11, 1, 7, 'h44, 1, 0, 0, "R7 write collides, old frame");
        lookup(7, 'h11, "R7 new frame visible");
        step(1, 3, 'h22, 1, 3, 'hA5, 0, 0, 0, "R7 invalidate collides, old present");
        lookup(3, 'h22, "R7 entry now absent");
        step(1, 7, 4, 0, 0, 0, 0, 1, 4, "R8 length write collides, old length");
        lookup(7, 4, "R8 new length applied");
        setlen(31);
        lookup(15, 'h1F0, "R8 length above entry count");
        for (int i = 0; i < 8; i++) lookup(i * 2 + 1, i * 37, "R2 back-to-back");
        idle(3);
        @(negedge clk);
        rst_n = 1'b0;
        sb.delete();
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        lookup(15, 9, "R1 reset restores length 0");
        setlen(16);
        lookup(15, 9, "R1 reset clears present bits");
        idle(3);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (5000) @(posedge clk);
                failures++;
                $display("FAIL watchdog: got timeout, exp completion");
            end
        join_any
        disable fork;
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R2 pending: got %0d unanswered, exp 0", sb.size());
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule